// File: doc/BRIEF.md
# Two-Wire Clock Configuration Register Slave

This block is the configuration front end of a clock synthesizer. It listens on a two-wire I2C bus as a write-only slave at standard or fast rate. It answers one of two fixed 7-bit addresses, and a strap pin picks which one. The first byte after the address is a command that selects one of four configuration registers. The data bytes that follow fill that register from its lowest byte upward.

There are four registers. One 32-bit register holds the settings of the unmodulated PLL. Three 48-bit registers, one for each spread-spectrum output, hold the divider, charge-pump, VCO-gain, modulation-period, modulation-depth, drive and slew settings. Every field appears on a parallel output port.

Bytes are staged while they arrive and reach the outputs only when the STOP condition is seen. The synthesizer therefore never runs on a half-written setting. The bus pins are oversampled by the block clock, which must run well above the bus rate. The block has no streaming data path, so it has no valid/ready interface; all of its pins are plain control and status lines.

Top module: `i2c_clkcfg_slave`

## Requirements
- R1: A write (R/W bit 0) to address 7'b1001111 is acknowledged when `addr_strap_i` is 0, and a write to 7'b1011111 when it is 1. The other of the two addresses, and every other address, gets no acknowledge: SDA stays released in the ninth clock.
- R2: The general-call address 7'b0000000 and any read request (R/W bit 1) are never acknowledged. The bytes that follow, up to the next START or STOP, change no output.
- R3: The command byte is always acknowledged. Command 0 selects the PLL register and commands 1, 2 and 3 select spread registers 0, 1 and 2. With any other command, the data bytes are acknowledged but change neither the fields nor `written_o`.
- R4: Data byte i of a transfer goes to register bits [8i+7:8i], least significant byte first. Every data byte is acknowledged, including bytes beyond the register width (4 bytes for the PLL register, 6 for a spread register), and those extra bytes are discarded.
- R5: The fields of a spread register are M in bits [11:0], N in [22:12], K in [27:23], modulation period L in [30:28], charge pump in [34:31], VCO gain in [40:35], modulation depth in [43:41], drive in bit 44 and slew in bit 45. Spread register s appears on slice s of each `ss_*` port. Bits 47:46 affect no output.
- R6: The fields of the PLL register are M in bits [5:0], N in [10:6], K in [15:11], charge pump in [19:16], VCO gain in [25:20], drive in bit 26 and slew in bit 27. Bits 31:28 affect no output.
- R7: Received bytes are committed at STOP. Before the STOP every output keeps its old value. A repeated START before the STOP throws away the bytes staged so far.
- R8: A write carrying fewer bytes than the register width changes only the bytes it carried. The other bytes keep their values.
- R9: After reset every field and every bit of `written_o` is 0. `written_o[c]` goes to 1 at the first committed write of at least one byte with command c (c = 0..3) and then stays at 1.
- R10: `sda_oe_o` = 1 pulls SDA low. It is asserted only for an acknowledge: from the SCL fall after the eighth bit of an accepted byte to the next SCL fall. At every other time SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| addr_strap_i | input | 1 | Selects which of the two slave addresses is answered |
| scl_i | input | 1 | Bus clock |
| sda_i | input | 1 | Bus data, as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| pll_m_o | output | 6 | PLL feedback divider M |
| pll_n_o | output | 5 | PLL reference divider N |
| pll_k_o | output | 5 | PLL output divider K |
| pll_cp_o | output | 4 | PLL charge-pump setting |
| pll_vco_o | output | 6 | PLL VCO gain |
| pll_drv_o | output | 1 | PLL output drive strength |
| pll_slew_o | output | 1 | PLL output slew select |
| ss_m_o | output | 36 | Spread M dividers, 12 bits per register |
| ss_n_o | output | 33 | Spread N dividers, 11 bits per register |
| ss_k_o | output | 15 | Spread K dividers, 5 bits per register |
| ss_l_o | output | 9 | Modulation period selects, 3 bits per register |
| ss_cp_o | output | 12 | Spread charge-pump settings, 4 bits per register |
| ss_vco_o | output | 18 | Spread VCO gains, 6 bits per register |
| ss_rate_o | output | 9 | Modulation depth codes, 3 bits per register |
| ss_drv_o | output | 3 | Spread drive strengths, 1 bit per register |
| ss_slew_o | output | 3 | Spread slew selects, 1 bit per register |
| written_o | output | 4 | Bit c set once register c has been committed |

## Verification
The bench probes the two addresses against both strap values, the general-call address and a read request. A decoder that checked too few address bits, or ignored the R/W bit, would acknowledge one of these. It stops a transfer right after its last data byte and compares the outputs before and after the STOP, which catches a design that writes bytes straight into live registers. It also breaks a transfer with a repeated START and sends bytes beyond the register width: a design that failed to drop the staged bytes would corrupt the register, and one that failed to saturate its byte index would corrupt a neighbouring byte. Short writes, a command that selects no register, and writes with every bit set in the top byte expose lanes or reserved bits that leak into the fields.

// File: rtl/i2c_clkcfg_pkg.sv
package i2c_clkcfg_pkg;
  localparam int NUM_REGS  = 4;
  localparam int REG_BYTES = 6;
  localparam int REG_W     = REG_BYTES * 8;
  localparam int PLL_BYTES = 4;
  localparam int IDX_W     = $clog2(REG_BYTES + 1);
  localparam logic [REG_W-1:0] PLL_KEEP = 48'h0000_0FFF_FFFF;
  localparam logic [REG_W-1:0] SS_KEEP  = 48'h3FFF_FFFF_FFFF;

  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_CMD, PH_DATA, PH_SKIP} phase_t;

  function automatic logic [REG_W-1:0] keep_mask(input int r);
    return (r == 0) ? PLL_KEEP : SS_KEEP;
  endfunction
endpackage

// File: rtl/i2c_clkcfg_sync.sv
module i2c_clkcfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_o;
    end
  end

  assign scl_s   = scl_sh[STAGES-1];
  assign sda_o   = sda_sh[STAGES-1];
  assign start_o = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o  = scl_s & scl_q & ~sda_q & sda_o;
  assign rise_o  = scl_s & ~scl_q;
  assign fall_o  = ~scl_s & scl_q;
endmodule

// File: rtl/i2c_clkcfg_link.sv
module i2c_clkcfg_link
  import i2c_clkcfg_pkg::*;
#(
  parameter logic [6:0] ADDR_STRAP0 = 7'b1001111,
  parameter logic [6:0] ADDR_STRAP1 = 7'b1011111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_i,
  input  logic       sda_s_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output logic       sda_oe_o,
  output logic       cmd_stb_o,
  output logic       data_stb_o,
  output logic [7:0] byte_o
);
  phase_t     phase;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic       ack_pend;
  logic [7:0] byte_now;
  logic [6:0] own_addr;
  logic       active;

  assign byte_now = {shreg[6:0], sda_s_i};
  assign own_addr = strap_i ? ADDR_STRAP1 : ADDR_STRAP0;
  assign active   = (phase == PH_ADDR) || (phase == PH_CMD) || (phase == PH_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      ack_pend   <= 1'b0;
      sda_oe_o   <= 1'b0;
      cmd_stb_o  <= 1'b0;
      data_stb_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      cmd_stb_o  <= 1'b0;
      data_stb_o <= 1'b0;
      if (start_i || stop_i) begin
        phase    <= start_i ? PH_ADDR : PH_IDLE;
        bit_cnt  <= '0;
        ack_pend <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (rise_i && active) begin
        if (bit_cnt == 4'd8) begin
          bit_cnt <= '0;
        end else begin
          shreg   <= byte_now;
          bit_cnt <= bit_cnt + 4'd1;
          if (bit_cnt == 4'd7) begin
            byte_o <= byte_now;
            unique case (phase)
              PH_ADDR: begin
                if (byte_now[7:1] == own_addr && !byte_now[0]) begin
                  ack_pend <= 1'b1;
                  phase    <= PH_CMD;
                end else begin
                  phase <= PH_SKIP;
                end
              end
              PH_CMD: begin
                ack_pend  <= 1'b1;
                cmd_stb_o <= 1'b1;
                phase     <= PH_DATA;
              end
              default: begin
                ack_pend   <= 1'b1;
                data_stb_o <= 1'b1;
              end
            endcase
          end
        end
      end else if (fall_i) begin
        sda_oe_o <= ack_pend;
        ack_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_clkcfg_bank.sv
module i2c_clkcfg_bank
  import i2c_clkcfg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic                      stop_i,
  input  logic                      cmd_stb_i,
  input  logic                      data_stb_i,
  input  logic [7:0]                byte_i,
  output logic [NUM_REGS*REG_W-1:0] cfg_o,
  output logic [NUM_REGS-1:0]       written_o
);
  logic [7:0]           sel_q;
  logic [IDX_W-1:0]     idx_q;
  logic [REG_BYTES-1:0] mask_q;
  logic [REG_W-1:0]     stage_q;
  logic [IDX_W-1:0]     cap;
  logic                 lane_ok;

  always_comb begin
    if (sel_q == 8'd0)                 cap = IDX_W'(PLL_BYTES);
    else if (sel_q < 8'(NUM_REGS))     cap = IDX_W'(REG_BYTES);
    else                               cap = '0;
  end
  assign lane_ok = data_stb_i && (idx_q < cap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 8'hFF;
      idx_q   <= '0;
      mask_q  <= '0;
      stage_q <= '0;
    end else if (start_i || cmd_stb_i) begin
      sel_q  <= cmd_stb_i ? byte_i : 8'hFF;
      idx_q  <= '0;
      mask_q <= '0;
    end else if (stop_i) begin
      mask_q <= '0;
    end else if (lane_ok) begin
      stage_q[idx_q*8 +: 8] <= byte_i;
      mask_q[idx_q]         <= 1'b1;
      idx_q                 <= idx_q + 1'b1;
    end
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [REG_W-1:0] cfg_q, merged;
    always_comb begin
      for (int b = 0; b < REG_BYTES; b++)
        merged[b*8 +: 8] = mask_q[b] ? stage_q[b*8 +: 8] : cfg_q[b*8 +: 8];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q        <= '0;
        written_o[r] <= 1'b0;
      end else if (stop_i && sel_q == 8'(r) && |mask_q) begin
        cfg_q        <= merged & keep_mask(r);
        written_o[r] <= 1'b1;
      end
    end
    assign cfg_o[r*REG_W +: REG_W] = cfg_q;
  end
endmodule

// File: rtl/i2c_clkcfg_slave.sv
module i2c_clkcfg_slave
  import i2c_clkcfg_pkg::*;
#(
  parameter logic [6:0] ADDR_STRAP0 = 7'b1001111,
  parameter logic [6:0] ADDR_STRAP1 = 7'b1011111,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_strap_i,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  output logic [5:0]  pll_m_o,
  output logic [4:0]  pll_n_o,
  output logic [4:0]  pll_k_o,
  output logic [3:0]  pll_cp_o,
  output logic [5:0]  pll_vco_o,
  output logic        pll_drv_o,
  output logic        pll_slew_o,
  output logic [35:0] ss_m_o,
  output logic [32:0] ss_n_o,
  output logic [14:0] ss_k_o,
  output logic [8:0]  ss_l_o,
  output logic [11:0] ss_cp_o,
  output logic [17:0] ss_vco_o,
  output logic [8:0]  ss_rate_o,
  output logic [2:0]  ss_drv_o,
  output logic [2:0]  ss_slew_o,
  output logic [3:0]  written_o
);
  logic sda_s, start_evt, stop_evt, rise_evt, fall_evt;
  logic cmd_stb, data_stb;
  logic [7:0] rx_byte;
  logic [NUM_REGS*REG_W-1:0] cfg_flat;
  logic [NUM_REGS-1:0] unused_hi;

  i2c_clkcfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_o(sda_s),
    .start_o(start_evt), .stop_o(stop_evt), .rise_o(rise_evt), .fall_o(fall_evt)
  );

  i2c_clkcfg_link #(.ADDR_STRAP0(ADDR_STRAP0), .ADDR_STRAP1(ADDR_STRAP1)) u_link (
    .clk(clk), .rst_n(rst_n), .strap_i(addr_strap_i), .sda_s_i(sda_s),
    .start_i(start_evt), .stop_i(stop_evt), .rise_i(rise_evt), .fall_i(fall_evt),
    .sda_oe_o(sda_oe_o), .cmd_stb_o(cmd_stb), .data_stb_o(data_stb), .byte_o(rx_byte)
  );

  i2c_clkcfg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .start_i(start_evt), .stop_i(stop_evt),
    .cmd_stb_i(cmd_stb), .data_stb_i(data_stb), .byte_i(rx_byte),
    .cfg_o(cfg_flat), .written_o(written_o)
  );

  assign pll_m_o    = cfg_flat[5:0];
  assign pll_n_o    = cfg_flat[10:6];
  assign pll_k_o    = cfg_flat[15:11];
  assign pll_cp_o   = cfg_flat[19:16];
  assign pll_vco_o  = cfg_flat[25:20];
  assign pll_drv_o  = cfg_flat[26];
  assign pll_slew_o = cfg_flat[27];
  assign unused_hi[0] = ^cfg_flat[REG_W-1:28];

  for (genvar s = 0; s < NUM_REGS - 1; s++) begin : g_ss
    localparam int B = (s + 1) * REG_W;
    assign ss_m_o[s*12 +: 12]  = cfg_flat[B +: 12];
    assign ss_n_o[s*11 +: 11]  = cfg_flat[B+12 +: 11];
    assign ss_k_o[s*5 +: 5]    = cfg_flat[B+23 +: 5];
    assign ss_l_o[s*3 +: 3]    = cfg_flat[B+28 +: 3];
    assign ss_cp_o[s*4 +: 4]   = cfg_flat[B+31 +: 4];
    assign ss_vco_o[s*6 +: 6]  = cfg_flat[B+35 +: 6];
    assign ss_rate_o[s*3 +: 3] = cfg_flat[B+41 +: 3];
    assign ss_drv_o[s]         = cfg_flat[B+44];
    assign ss_slew_o[s]        = cfg_flat[B+45];
    assign unused_hi[s+1]      = ^cfg_flat[B+46 +: 2];
  end
endmodule

// File: rtl/i2c_clkcfg_chk.sv
module i2c_clkcfg_chk
  import i2c_clkcfg_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      scl_i,
  input logic                      sda_oe_o,
  input logic                      stop_evt,
  input logic [NUM_REGS-1:0]       written_o,
  input logic [NUM_REGS*REG_W-1:0] cfg_all
);
  assert_ack_on_low_scl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_i);

  assert_release_on_low_scl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> !scl_i);

  assert_release_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe_o);

  assert_fields_commit_at_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_all) |-> $past(stop_evt));

  assert_flags_commit_at_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(written_o) |-> $past(stop_evt));

  assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(written_o) & ~written_o) == '0);
endmodule

bind i2c_clkcfg_slave i2c_clkcfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .stop_evt(stop_evt), .written_o(written_o), .cfg_all(cfg_flat)
);

// File: tb/i2c_clkcfg_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_clkcfg_slave_tb_top;
  localparam int Q = 8;
  localparam logic [6:0] A0 = 7'b1001111;
  localparam logic [6:0] A1 = 7'b1011111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic ack_win = 1'b0;
  wire  sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  wire [5:0] pll_m, pll_vco; wire [4:0] pll_n, pll_k; wire [3:0] pll_cp;
  wire pll_drv, pll_slew;
  wire [35:0] ss_m; wire [32:0] ss_n; wire [14:0] ss_k; wire [8:0] ss_l, ss_rate;
  wire [11:0] ss_cp; wire [17:0] ss_vco; wire [2:0] ss_drv, ss_slew; wire [3:0] written;

  int checks = 0, failures = 0, bad_oe = 0;
  logic [47:0] img [4];
  logic [3:0]  wr_exp;
  logic [7:0]  tx [8];

  always #2.5 clk = ~clk;

  i2c_clkcfg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .addr_strap_i(strap), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .pll_m_o(pll_m), .pll_n_o(pll_n), .pll_k_o(pll_k), .pll_cp_o(pll_cp),
    .pll_vco_o(pll_vco), .pll_drv_o(pll_drv), .pll_slew_o(pll_slew), .ss_m_o(ss_m),
    .ss_n_o(ss_n), .ss_k_o(ss_k), .ss_l_o(ss_l), .ss_cp_o(ss_cp), .ss_vco_o(ss_vco),
    .ss_rate_o(ss_rate), .ss_drv_o(ss_drv), .ss_slew_o(ss_slew), .written_o(written)
  );

  always @(negedge clk) if (rst_n && sda_oe && !ack_win) bad_oe++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] keep(input int r);
    return (r == 0) ? 48'h0000_0FFF_FFFF : 48'h3FFF_FFFF_FFFF;
  endfunction

  function automatic logic [47:0] read_reg(input int r);
    int i;
    if (r == 0) return {20'b0, pll_slew, pll_drv, pll_vco, pll_cp, pll_k, pll_n, pll_m};
    i = r - 1;
    return {2'b00, ss_slew[i], ss_drv[i], ss_rate[i*3 +: 3], ss_vco[i*6 +: 6], ss_cp[i*4 +: 4],
            ss_l[i*3 +: 3], ss_k[i*5 +: 5], ss_n[i*11 +: 11], ss_m[i*12 +: 12]};
  endfunction

  task automatic check_all(input string req);
    for (int r = 0; r < 4; r++) check(req, 64'(read_reg(r)), 64'(img[r] & keep(r)));
    check(req, 64'(written), 64'(wr_exp));
  endtask

  task automatic model(input int cmd, input int n);
    int nb;
    if (cmd > 3) return;
    nb = (cmd == 0) ? 4 : 6;
    for (int i = 0; i < n && i < nb; i++) img[cmd][i*8 +: 8] = tx[i];
    if (n > 0) wr_exp[cmd] = 1'b1;
  endtask

  task automatic qwait; repeat (Q) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1'b1; qwait; scl_m = 1'b1; qwait; sda_m = 1'b0; qwait; scl_m = 1'b0; qwait;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; qwait; scl_m = 1'b1; qwait; sda_m = 1'b1; qwait; qwait;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = v[i]; qwait; scl_m = 1'b1; qwait; qwait;
      if (i == 0) ack_win = 1'b1;
      scl_m = 1'b0; qwait;
    end
    sda_m = 1'b1; qwait; scl_m = 1'b1; qwait;
    acked = !sda_line;
    qwait; scl_m = 1'b0;
    repeat (6) @(negedge clk);
    ack_win = 1'b0;
    repeat (Q - 6) @(negedge clk);
  endtask

  task automatic xfer(input logic [6:0] a, input logic rw, input logic [7:0] cmd,
                      input int n, input bit stop, output logic aack, output logic dack);
    logic k;
    bus_start;
    send_byte({a, rw}, aack);
    dack = 1'b1;
    if (aack) begin
      send_byte(cmd, k); dack &= k;
      for (int i = 0; i < n; i++) begin send_byte(tx[i], k); dack &= k; end
    end
    if (stop) bus_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic aa, da;
    int seed_v, cmd, n;
    seed_v = $urandom(32'd715);
    for (int r = 0; r < 4; r++) img[r] = '0;
    wr_exp = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_all("R9 reset");

    tx[0] = 8'hA5; tx[1] = 8'h3C; tx[2] = 8'hE7; tx[3] = 8'hF9;
    xfer(A0, 1'b0, 8'd0, 4, 1'b1, aa, da);
    check("R1 addr ack strap0", 64'(aa), 64'd1);
    check("R4 data ack", 64'(da), 64'd1);
    model(0, 4); check_all("R6 pll layout");

    xfer(A1, 1'b0, 8'd0, 0, 1'b1, aa, da);
    check("R1 other addr nack strap0", 64'(aa), 64'd0);

    strap = 1'b1;
    tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33; tx[3] = 8'h44; tx[4] = 8'h55; tx[5] = 8'hFF;
    xfer(A1, 1'b0, 8'd1, 6, 1'b1, aa, da);
    check("R1 addr ack strap1", 64'(aa), 64'd1);
    model(1, 6); check_all("R5 spread layout reserved");
    xfer(A0, 1'b0, 8'd1, 0, 1'b1, aa, da);
    check("R1 addr nack strap1", 64'(aa), 64'd0);
    xfer(7'h00, 1'b0, 8'd1, 0, 1'b1, aa, da);
    check("R2 general call nack", 64'(aa), 64'd0);
    xfer(A1, 1'b1, 8'd1, 0, 1'b1, aa, da);
    check("R2 read nack", 64'(aa), 64'd0);
    check_all("R2 no change");

    tx[0] = 8'h99; tx[1] = 8'h88; tx[2] = 8'h77;
    xfer(A1, 1'b0, 8'd7, 3, 1'b1, aa, da);
    check("R3 bad cmd acked", 64'(aa & da), 64'd1);
    check_all("R3 bad cmd discarded");

    tx[0] = 8'hC3; tx[1] = 8'h5A;
    xfer(A1, 1'b0, 8'd2, 2, 1'b1, aa, da);
    model(2, 2); check_all("R8 partial write");

    for (int i = 0; i < 6; i++) tx[i] = 8'(8'h60 + i);
    xfer(A1, 1'b0, 8'd3, 6, 1'b0, aa, da);
    repeat (20) @(negedge clk);
    check_all("R7 before stop");
    bus_stop; model(3, 6); check_all("R7 after stop");

    for (int i = 0; i < 3; i++) tx[i] = 8'hEE;
    xfer(A1, 1'b0, 8'd3, 3, 1'b0, aa, da);
    tx[0] = 8'h0F;
    xfer(A1, 1'b0, 8'd0, 1, 1'b1, aa, da);
    model(0, 1); check_all("R7 repeated start discards");

    for (int i = 0; i < 6; i++) tx[i] = 8'(8'hD0 + i);
    xfer(A1, 1'b0, 8'd0, 6, 1'b1, aa, da);
    check("R4 extra bytes acked", 64'(da), 64'd1);
    model(0, 6); check_all("R4 extra bytes dropped");

    for (int t = 0; t < 18; t++) begin
      cmd = $urandom_range(0, 4);
      if (cmd == 4) cmd = 9;
      n = $urandom_range(1, 6);
      for (int i = 0; i < n; i++) tx[i] = 8'($urandom);
      xfer(A1, 1'b0, 8'(cmd), n, 1'b1, aa, da);
      check("R3 R4 random acks", 64'(aa & da), 64'd1);
      model(cmd, n); check_all("R5 R6 R8 random");
    end

    check("R10 sda only driven in ack", 64'(bad_oe), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule